// File: doc/BRIEF.md
# Panel Register Write Sequencer over SPI

This block turns single register-write requests into the two-frame serial exchange that a small display panel controller expects. A request carries an 8-bit register number and a 16-bit value and is taken on a valid/ready handshake. The block then sends two 24-bit frames, each framed by its own chip-select pulse. The first frame is an index frame that selects the register. The second is a data frame that carries the value. The serial clock uses SPI mode 3 and its speed comes from a divider input.

A second command input starts a built-in power-up sequence. This sequence first writes the "on" value to the panel's shutdown-control register. It then writes the output-control register with a value built from four scan and colour mode bits merged into a fixed base pattern. Both kinds of command share the same ready signal, so the host simply waits for ready before it issues the next command.

Top module: `panel_spi_writer`

## Requirements
- R1: After reset, `req_ready` is 1, `spi_cs_n` is 1 and `spi_sck` is 1.
- R2: The first frame of a write is 24 bits, sent MSB first: 0x74, then 0x00, then the register number.
- R3: The second frame of a write is 24 bits, sent MSB first: 0x76, then value bits 15:8, then value bits 7:0.
- R4: `spi_cs_n` goes low and returns high around each 24-bit frame on its own. Between the two frames it stays high for at least one full serial clock period, which is 2*(clk_div+1) system cycles.
- R5: Mode 3 signalling holds throughout. `spi_sck` is high whenever `spi_cs_n` is high. `spi_mosi` does not change while `spi_sck` stays high inside a frame. The receiver samples on rising edges, and the first bit is already on the line when chip select falls.
- R6: Each low and each high phase of `spi_sck` lasts clk_div+1 system cycles. The value of `clk_div` is latched at the start of each frame.
- R7: `req_ready` drops in the cycle after a command is accepted. It stays low until the last frame's chip select has been released. A request or init pulse that arrives while `req_ready` is low is ignored.
- R8: An init command sends four frames in this order. First, register 0x11 is written with 0x0000, which means powered on (bit 0 = 1 would mean shutdown). Second, register 0x01 is written with the output-control value.
- R9: The output-control value is (init_mode & 0x2B00) | 0x00EF. The kept bits are 8 (left-to-right scan), 9 (top-to-bottom), 11 (BGR order) and 13 (normal display). For example, mode 0x2A00 gives 0x2AEF.
- R10: If `init_valid` and `req_valid` are both high in an accepting cycle, the init sequence runs and the register request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_div | input | DIV_W | Half-period of the serial clock, minus one, in system cycles |
| req_valid | input | 1 | Register write request |
| req_addr | input | 8 | Register number to write |
| req_value | input | 16 | Value to write |
| init_valid | input | 1 | Start the power-up sequence |
| init_mode | input | 16 | Mode bits used to build the output-control value |
| req_ready | output | 1 | Block is idle and can accept a command |
| spi_sck | output | 1 | Serial clock, idles high |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the panel |

## Verification
Some properties are checked by assertions on every cycle. These are the idle-high clock while chip select is released, the stable data line while the clock is high inside a frame, the ready signal being low whenever chip select is low, the drop of ready after every acceptance, and the minimum high time of chip select after each release. Other behaviour can only be shown by the bench's scenarios. This includes the frame contents and bit order, the two-frame split per command, the init sequence order and its composed value, the priority between the two command inputs, the phase length for each divider value, and the fact that commands arriving while busy are dropped.

// File: rtl/panel_spi_pkg.sv
package panel_spi_pkg;
   localparam int FRAME_W = 24;
   localparam int BYTE_W  = 8;
   localparam int VAL_W   = 16;

   localparam logic [BYTE_W-1:0] REG_SHUTDOWN   = 8'h11;
   localparam logic [BYTE_W-1:0] REG_OUT_CTRL   = 8'h01;
   localparam logic [VAL_W-1:0]  POWER_ON_VALUE = 16'h0000;
   localparam logic [VAL_W-1:0]  MODE_KEEP_MASK = 16'h2B00;
   localparam logic [VAL_W-1:0]  OUT_CTRL_BASE  = 16'h2AEF;

   typedef enum logic [2:0] {
      ENG_IDLE, ENG_LEAD, ENG_LOW, ENG_HIGH, ENG_TRAIL, ENG_GAP
   } eng_state_t;

   typedef enum logic [2:0] {
      SEQ_IDLE, SEQ_IDX_GO, SEQ_IDX_WAIT, SEQ_DAT_GO, SEQ_DAT_WAIT
   } seq_state_t;

   function automatic logic [VAL_W-1:0] out_ctrl_value(input logic [VAL_W-1:0] mode);
      return (mode & MODE_KEEP_MASK) | (OUT_CTRL_BASE & ~MODE_KEEP_MASK);
   endfunction
endpackage

// File: rtl/pspi_engine.sv
module pspi_engine
   import panel_spi_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter bit REG_OUTPUTS = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DIV_W-1:0]   div,
   input  logic               start,
   input  logic [FRAME_W-1:0] frame,
   output logic               done,
   output logic               sck,
   output logic               cs_n,
   output logic               mosi
);
   localparam int BIT_CNT_W = $clog2(FRAME_W);

   eng_state_t           state;
   logic [DIV_W-1:0]     half_cnt;
   logic [DIV_W-1:0]     div_q;
   logic [FRAME_W-1:0]   shreg;
   logic [BIT_CNT_W-1:0] bit_cnt;
   logic                 gap_second;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ENG_IDLE;
         half_cnt   <= '0;
         div_q      <= '0;
         shreg      <= '0;
         bit_cnt    <= '0;
         gap_second <= 1'b0;
         done       <= 1'b0;
      end else begin
         done <= 1'b0;
         if (state == ENG_IDLE) begin
            if (start) begin
               shreg    <= frame;
               bit_cnt  <= BIT_CNT_W'(FRAME_W - 1);
               div_q    <= div;
               half_cnt <= div;
               state    <= ENG_LEAD;
            end
         end else if (half_cnt != '0) begin
            half_cnt <= half_cnt - 1'b1;
         end else begin
            half_cnt <= div_q;
            case (state)
               ENG_LEAD: state <= ENG_LOW;
               ENG_LOW:  state <= ENG_HIGH;
               ENG_HIGH: begin
                  if (bit_cnt == '0) begin
                     state <= ENG_TRAIL;
                  end else begin
                     shreg   <= {shreg[FRAME_W-2:0], 1'b0};
                     bit_cnt <= bit_cnt - 1'b1;
                     state   <= ENG_LOW;
                  end
               end
               ENG_TRAIL: begin
                  gap_second <= 1'b0;
                  state      <= ENG_GAP;
               end
               ENG_GAP: begin
                  if (gap_second) begin
                     state <= ENG_IDLE;
                     done  <= 1'b1;
                  end else begin
                     gap_second <= 1'b1;
                  end
               end
               default: state <= ENG_IDLE;
            endcase
         end
      end
   end

   logic sck_d, cs_n_d, mosi_d;
   always_comb begin
      sck_d  = (state != ENG_LOW);
      cs_n_d = (state == ENG_IDLE) || (state == ENG_GAP);
      mosi_d = cs_n_d ? 1'b0 : shreg[FRAME_W-1];
   end

   generate
      if (REG_OUTPUTS) begin : g_reg_out
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sck  <= 1'b1;
               cs_n <= 1'b1;
               mosi <= 1'b0;
            end else begin
               sck  <= sck_d;
               cs_n <= cs_n_d;
               mosi <= mosi_d;
            end
         end
      end else begin : g_comb_out
         assign sck  = sck_d;
         assign cs_n = cs_n_d;
         assign mosi = mosi_d;
      end
   endgenerate
endmodule

// File: rtl/pspi_seq.sv
module pspi_seq
   import panel_spi_pkg::*;
#(
   parameter logic [BYTE_W-1:0] CMD_INDEX = 8'h74,
   parameter logic [BYTE_W-1:0] CMD_DATA  = 8'h76
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [BYTE_W-1:0]  req_addr,
   input  logic [VAL_W-1:0]   req_value,
   input  logic               init_valid,
   input  logic [VAL_W-1:0]   init_mode,
   output logic               req_ready,
   output logic               eng_start,
   output logic [FRAME_W-1:0] eng_frame,
   input  logic               eng_done
);
   seq_state_t          st;
   logic [BYTE_W-1:0]   addr_q;
   logic [VAL_W-1:0]    val_q;
   logic [VAL_W-1:0]    mode_q;
   logic                init_pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= SEQ_IDLE;
         addr_q    <= '0;
         val_q     <= '0;
         mode_q    <= '0;
         init_pend <= 1'b0;
      end else begin
         case (st)
            SEQ_IDLE: begin
               if (init_valid) begin
                  addr_q    <= REG_SHUTDOWN;
                  val_q     <= POWER_ON_VALUE;
                  mode_q    <= init_mode;
                  init_pend <= 1'b1;
                  st        <= SEQ_IDX_GO;
               end else if (req_valid) begin
                  addr_q    <= req_addr;
                  val_q     <= req_value;
                  init_pend <= 1'b0;
                  st        <= SEQ_IDX_GO;
               end
            end
            SEQ_IDX_GO:   st <= SEQ_IDX_WAIT;
            SEQ_IDX_WAIT: if (eng_done) st <= SEQ_DAT_GO;
            SEQ_DAT_GO:   st <= SEQ_DAT_WAIT;
            SEQ_DAT_WAIT: begin
               if (eng_done) begin
                  if (init_pend) begin
                     addr_q    <= REG_OUT_CTRL;
                     val_q     <= out_ctrl_value(mode_q);
                     init_pend <= 1'b0;
                     st        <= SEQ_IDX_GO;
                  end else begin
                     st <= SEQ_IDLE;
                  end
               end
            end
            default: st <= SEQ_IDLE;
         endcase
      end
   end

   logic index_phase;
   always_comb begin
      index_phase = (st == SEQ_IDX_GO) || (st == SEQ_IDX_WAIT);
      req_ready   = (st == SEQ_IDLE);
      eng_start   = (st == SEQ_IDX_GO) || (st == SEQ_DAT_GO);
      eng_frame   = index_phase ? {CMD_INDEX, {BYTE_W{1'b0}}, addr_q}
                                : {CMD_DATA, val_q};
   end
endmodule

// File: rtl/panel_spi_writer.sv
module panel_spi_writer
   import panel_spi_pkg::*;
#(
   parameter int                DIV_W       = 8,
   parameter bit                REG_OUTPUTS = 1'b1,
   parameter logic [BYTE_W-1:0] CMD_INDEX   = 8'h74,
   parameter logic [BYTE_W-1:0] CMD_DATA    = 8'h76
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] clk_div,
   input  logic             req_valid,
   input  logic [7:0]       req_addr,
   input  logic [15:0]      req_value,
   input  logic             init_valid,
   input  logic [15:0]      init_mode,
   output logic             req_ready,
   output logic             spi_sck,
   output logic             spi_cs_n,
   output logic             spi_mosi
);
   generate
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
         $error("panel_spi_writer: DIV_W must be 1..16");
      end
      if (FRAME_W != 3 * BYTE_W) begin : g_bad_frame
         $error("panel_spi_writer: frame must hold three bytes");
      end
   endgenerate

   logic               eng_start;
   logic               eng_done;
   logic [FRAME_W-1:0] eng_frame;

   pspi_seq #(
      .CMD_INDEX (CMD_INDEX),
      .CMD_DATA  (CMD_DATA)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_addr   (req_addr),
      .req_value  (req_value),
      .init_valid (init_valid),
      .init_mode  (init_mode),
      .req_ready  (req_ready),
      .eng_start  (eng_start),
      .eng_frame  (eng_frame),
      .eng_done   (eng_done)
   );

   pspi_engine #(
      .DIV_W       (DIV_W),
      .REG_OUTPUTS (REG_OUTPUTS)
   ) u_eng (
      .clk   (clk),
      .rst_n (rst_n),
      .div   (clk_div),
      .start (eng_start),
      .frame (eng_frame),
      .done  (eng_done),
      .sck   (spi_sck),
      .cs_n  (spi_cs_n),
      .mosi  (spi_mosi)
   );
endmodule

// File: rtl/panel_spi_writer_chk.sv
module panel_spi_writer_chk (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic init_valid,
   input logic req_ready,
   input logic spi_sck,
   input logic spi_cs_n,
   input logic spi_mosi
);
   // R5
   sck_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> spi_sck);

   // R5
   mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!spi_cs_n && spi_sck && $past(!spi_cs_n) && $past(spi_sck)) |-> $stable(spi_mosi));

   // R7
   busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !spi_cs_n |-> !req_ready);

   // R7
   accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((req_valid || init_valid) && req_ready) |=> !req_ready);

   // R4
   cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_cs_n) |=> spi_cs_n);
endmodule

bind panel_spi_writer panel_spi_writer_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .init_valid (init_valid),
   .req_ready  (req_ready),
   .spi_sck    (spi_sck),
   .spi_cs_n   (spi_cs_n),
   .spi_mosi   (spi_mosi)
);

// File: tb/tb_panel_spi_writer.sv
module tb_panel_spi_writer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  clk_div = 8'd0;
   logic        req_valid = 1'b0;
   logic [7:0]  req_addr = 8'd0;
   logic [15:0] req_value = 16'd0;
   logic        init_valid = 1'b0;
   logic [15:0] init_mode = 16'd0;
   logic        req_ready, spi_sck, spi_cs_n, spi_mosi;

   always #2.5 clk = ~clk;

   panel_spi_writer dut (
      .clk(clk), .rst_n(rst_n), .clk_div(clk_div),
      .req_valid(req_valid), .req_addr(req_addr), .req_value(req_value),
      .init_valid(init_valid), .init_mode(init_mode),
      .req_ready(req_ready), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi)
   );

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   // serial-side monitor
   logic [23:0] frm [0:15];
   logic [23:0] sh = '0;
   int nfrm = 0, bits = 0, badbits = 0;
   int gapc = 0, min_gap = 1000000, seen_rise = 0;
   int lowc = 0, lo_min = 1000000, lo_max = 0;
   int ready_viol = 0;
   logic prev_sck = 1'b1, prev_cs = 1'b1;

   always @(negedge clk) begin
      cycles++;
      if (rst_n) begin
         if (!spi_cs_n && spi_sck && !prev_sck) begin
            sh = {sh[22:0], spi_mosi};
            bits++;
         end
         if (spi_cs_n && !prev_cs) begin
            if (nfrm < 16) frm[nfrm] = sh;
            if (bits != 24) badbits++;
            nfrm++;
            bits = 0;
            gapc = 0;
            seen_rise = 1;
         end
         if (!spi_cs_n && prev_cs) begin
            if (seen_rise != 0 && gapc < min_gap) min_gap = gapc;
            bits = 0;
         end
         if (spi_cs_n) gapc++;
         if (!spi_sck) lowc++;
         if (spi_sck && !prev_sck) begin
            if (lowc < lo_min) lo_min = lowc;
            if (lowc > lo_max) lo_max = lowc;
            lowc = 0;
         end
         if (!spi_cs_n && req_ready) ready_viol++;
      end
      prev_sck = spi_sck;
      prev_cs  = spi_cs_n;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic clear_cap();
      nfrm = 0; bits = 0; badbits = 0; seen_rise = 0; min_gap = 1000000;
      lowc = 0; lo_min = 1000000; lo_max = 0; ready_viol = 0;
   endtask

   task automatic wait_idle();
      int n = 0;
      while (!req_ready && n < 20000) begin
         @(negedge clk);
         n++;
      end
      repeat (4) @(negedge clk);
   endtask

   task automatic send_req(input logic [7:0] a, input logic [15:0] v);
      @(negedge clk);
      req_addr = a; req_value = v; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic send_init(input logic [15:0] m);
      @(negedge clk);
      init_mode = m; init_valid = 1'b1;
      @(negedge clk);
      init_valid = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 ready", {31'd0, req_ready}, 32'd1);
      check("R1 cs_n", {31'd0, spi_cs_n}, 32'd1);
      check("R1 sck",  {31'd0, spi_sck}, 32'd1);
   endtask

   task automatic t_write(input logic [7:0] a, input logic [15:0] v, input logic [7:0] d);
      clk_div = d;
      clear_cap();
      send_req(a, v);
      check("R7 ready low after accept", {31'd0, req_ready}, 32'd0);
      wait_idle();
      check("R2 R3 frame count", nfrm, 2);
      check("R2 index frame", {8'd0, frm[0]}, {8'd0, 8'h74, 8'h00, a});
      check("R3 data frame", {8'd0, frm[1]}, {8'd0, 8'h76, v});
      check("R2 bits per frame", badbits, 0);
      check("R4 cs gap", {31'd0, min_gap >= 2 * (d + 1)}, 32'd1);
      check("R6 low phase min", lo_min, d + 1);
      check("R6 low phase max", lo_max, d + 1);
      check("R7 ready while cs low", ready_viol, 0);
   endtask

   task automatic t_init(input logic [15:0] m, input logic [15:0] exp_val);
      clk_div = 8'd1;
      clear_cap();
      send_init(m);
      wait_idle();
      check("R8 frame count", nfrm, 4);
      check("R8 shutdown index", {8'd0, frm[0]}, 32'h00740011);
      check("R8 power-on data", {8'd0, frm[1]}, 32'h00760000);
      check("R8 out-ctrl index", {8'd0, frm[2]}, 32'h00740001);
      check("R9 out-ctrl value", {8'd0, frm[3]}, {8'd0, 8'h76, exp_val});
      check("R4 gaps in init", {31'd0, min_gap >= 4}, 32'd1);
   endtask

   task automatic t_ignore();
      clk_div = 8'd2;
      clear_cap();
      send_req(8'h3C, 16'h1234);
      repeat (20) @(negedge clk);
      req_addr = 8'hC3; req_value = 16'hFFFF; req_valid = 1'b1; init_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0; init_valid = 1'b0;
      wait_idle();
      repeat (60) @(negedge clk);
      check("R7 busy commands dropped", nfrm, 2);
      check("R7 first request kept", {8'd0, frm[1]}, 32'h00761234);
      check("R7 idle after drop", {30'd0, spi_cs_n, req_ready}, 32'd3);
   endtask

   task automatic t_prio();
      clk_div = 8'd0;
      clear_cap();
      @(negedge clk);
      req_addr = 8'h55; req_value = 16'hAAAA; req_valid = 1'b1;
      init_mode = 16'h2A00; init_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0; init_valid = 1'b0;
      wait_idle();
      check("R10 init wins count", nfrm, 4);
      check("R10 init wins first", {8'd0, frm[0]}, 32'h00740011);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write(8'h5A, 16'hBEEF, 8'd0);
      t_write(8'hFF, 16'h0001, 8'd3);
      t_write(8'h00, 16'h8000, 8'd1);
      t_init(16'h2A00, 16'h2AEF);
      t_init(16'hFFFF, 16'h2BEF);
      t_init(16'h0000, 16'h00EF);
      t_ignore();
      t_prio();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      wait (cycles > 150000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule